// File: doc/BRIEF.md
# Time-Stepped External Spike Injector

This block takes event bytes produced outside a spiking processor array and turns them into forced spikes on a group of neurons, each at the right emulation step. Every byte arrives in one cycle as two 4-bit halves on two parallel lanes. A decoder joins the halves into one word, with each lane bit wired straight to its bit of the word, so no shifting is needed. The word then waits in a FIFO until the next time-step strobe, which arrives about once per millisecond of emulated time.

At each strobe the oldest stored word becomes the override vector for that step. Each bit of the vector belongs to one neuron. A registered multiplexer places the vector on the neurons' spike outputs, in place of their own values, while the array processes the chosen virtual layer. On every other layer, and on any step that has no word, the neurons' own spikes pass through unchanged. Layer 0 is the usual target, and the layer select can pick any of the virtual layers.

Top module: `spike_injector`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `override_o`, `spike_o`, `inject_active_o`, `underflow_o` and `overflow_o` are all zero.
- R2: When `lane_valid_i` is high, the word stored is {`lane_hi_i`, `lane_lo_i`}. The low lane supplies bits 3:0 and the high lane supplies bits 7:4, both taken in that same cycle.
- R3: A word given with valid at edge N can be released by a `step_tick_i` sampled at edge N+2 or later. Words are released in the order they arrived, one word per tick.
- R4: On a tick with a stored word, `override_o` takes that word and `inject_active_o` goes high at the same edge. Both keep their values until the next tick.
- R5: On a tick with no stored word, `override_o` and `inject_active_o` clear at that edge, and `underflow_o` is high for exactly that one cycle.
- R6: A word that arrives while the FIFO holds DEPTH words (16 by default) is dropped and the stored words are kept. `overflow_o` then goes high and stays high until reset.
- R7: One edge after `inject_active_o` is high and `cur_layer_i` equals `layer_sel_i`, `spike_o` equals `override_o`. At any other time `spike_o` is `neuron_spike_i` from the previous cycle. This holds for any layer value from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_lo_i | input | 4 | Low half (bits 3:0) of the event word |
| lane_hi_i | input | 4 | High half (bits 7:4) of the event word |
| lane_valid_i | input | 1 | Both lanes carry a word this cycle |
| step_tick_i | input | 1 | Time-step strobe, one cycle wide |
| layer_sel_i | input | 3 | Virtual layer that receives the injection |
| cur_layer_i | input | 3 | Virtual layer the array is processing now |
| neuron_spike_i | input | 8 | Neurons' own spike outputs |
| spike_o | output | 8 | Spike outputs after the multiplexer (registered) |
| override_o | output | 8 | Override vector for the current step |
| inject_active_o | output | 1 | A word is being injected during this step |
| underflow_o | output | 1 | One-cycle pulse: a tick found the FIFO empty |
| overflow_o | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
A swapped or mis-wired lane shows in `override_o` at the first tick that releases the affected word. A wrong FIFO pointer or count shows as words out of order or repeated, or as a false underflow, at the tick where the bench's queue and the design disagree. If the design drops a word when it should keep it, or keeps one it should drop, `overflow_o` or the drained sequence is wrong as soon as the FIFO has been filled past its depth. A fault in the multiplexer's layer compare appears on `spike_o` one cycle after a layer match or mismatch is driven.

// File: rtl/spk_inj_pkg.sv
package spk_inj_pkg;
  localparam int unsigned VLAYERS = 8;
  localparam int unsigned LAYER_W = $clog2(VLAYERS);
  typedef logic [LAYER_W-1:0] layer_t;
endpackage

// File: rtl/nibble_decoder.sv
module nibble_decoder #(
  parameter int unsigned LANE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANE_W-1:0]     lo_i,
  input  logic [LANE_W-1:0]     hi_i,
  input  logic                  vld_i,
  output logic [2*LANE_W-1:0]   word_q,
  output logic                  vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) word_q <= {hi_i, lo_i};
    end
  end
endmodule

// File: rtl/step_fifo.sv
module step_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             tick_i,
  output logic [WIDTH-1:0] rd_data_q,
  output logic             rd_hit_q,
  output logic             underflow_q,
  output logic             overflow_q
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_wr, do_rd, empty, full;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign do_wr = wr_en_i && !full;
  assign do_rd = tick_i && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      rd_data_q   <= '0;
      rd_hit_q    <= 1'b0;
      underflow_q <= 1'b0;
      overflow_q  <= 1'b0;
    end else begin
      underflow_q <= tick_i && empty;
      if (wr_en_i && full) overflow_q <= 1'b1;
      if (do_wr) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (tick_i) begin
        rd_hit_q  <= !empty;
        rd_data_q <= empty ? '0 : mem[rd_ptr];
      end
    end
  end
endmodule

// File: rtl/spike_mux.sv
module spike_mux
  import spk_inj_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active_i,
  input  logic [N-1:0] override_i,
  input  layer_t       layer_sel_i,
  input  layer_t       cur_layer_i,
  input  logic [N-1:0] own_i,
  output logic [N-1:0] spike_q
);
  logic hit;
  assign hit = active_i && (cur_layer_i == layer_sel_i);

  always_ff @(posedge clk) begin
    if (rst) spike_q <= '0;
    else     spike_q <= hit ? override_i : own_i;
  end
endmodule

// File: rtl/spike_injector.sv
module spike_injector
  import spk_inj_pkg::*;
#(
  parameter int unsigned LANE_W = 4,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] lane_lo_i,
  input  logic [LANE_W-1:0] lane_hi_i,
  input  logic              lane_valid_i,
  input  logic              step_tick_i,
  input  logic [LAYER_W-1:0] layer_sel_i,
  input  logic [LAYER_W-1:0] cur_layer_i,
  input  logic [WORD_W-1:0] neuron_spike_i,
  output logic [WORD_W-1:0] spike_o,
  output logic [WORD_W-1:0] override_o,
  output logic              inject_active_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  logic [WORD_W-1:0] dec_word;
  logic              dec_vld;

  nibble_decoder #(.LANE_W(LANE_W)) u_dec (
    .clk(clk), .rst(rst), .lo_i(lane_lo_i), .hi_i(lane_hi_i),
    .vld_i(lane_valid_i), .word_q(dec_word), .vld_q(dec_vld)
  );

  step_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en_i(dec_vld), .wr_data_i(dec_word),
    .tick_i(step_tick_i), .rd_data_q(override_o), .rd_hit_q(inject_active_o),
    .underflow_q(underflow_o), .overflow_q(overflow_o)
  );

  spike_mux #(.N(WORD_W)) u_mux (
    .clk(clk), .rst(rst), .active_i(inject_active_o), .override_i(override_o),
    .layer_sel_i(layer_sel_i), .cur_layer_i(cur_layer_i),
    .own_i(neuron_spike_i), .spike_q(spike_o)
  );
endmodule

// File: rtl/spike_injector_chk.sv
module spike_injector_chk
  import spk_inj_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              step_tick_i,
  input logic [LAYER_W-1:0] layer_sel_i,
  input logic [LAYER_W-1:0] cur_layer_i,
  input logic [WORD_W-1:0] neuron_spike_i,
  input logic [WORD_W-1:0] spike_o,
  input logic [WORD_W-1:0] override_o,
  input logic              inject_active_o,
  input logic              underflow_o,
  input logic              overflow_o
);
  a_r5_underflow_from_tick: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> $past(step_tick_i));
  a_r5_underflow_clears: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> (!inject_active_o && override_o == '0));
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);
  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !step_tick_i |=> ($stable(override_o) && $stable(inject_active_o)));
  a_r7_passthrough: assert property (@(posedge clk) disable iff (rst)
    (!inject_active_o || cur_layer_i != layer_sel_i) |=> spike_o == $past(neuron_spike_i));
  a_r7_inject: assert property (@(posedge clk) disable iff (rst)
    (inject_active_o && cur_layer_i == layer_sel_i) |=> spike_o == $past(override_o));
endmodule

bind spike_injector spike_injector_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .step_tick_i(step_tick_i), .layer_sel_i(layer_sel_i),
  .cur_layer_i(cur_layer_i), .neuron_spike_i(neuron_spike_i), .spike_o(spike_o),
  .override_o(override_o), .inject_active_o(inject_active_o),
  .underflow_o(underflow_o), .overflow_o(overflow_o)
);

// File: tb/spike_injector_tb.sv
module spike_injector_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] lane_lo = '0, lane_hi = '0;
  logic       lane_valid = 1'b0, tick = 1'b0;
  logic [2:0] layer_sel = '0, cur_layer = '0;
  logic [7:0] nspk = '0;
  logic [7:0] spike, ovr;
  logic       act, uf, of;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  logic [7:0] q[$];
  logic [7:0] e_ovr = '0;
  logic       e_act = 1'b0, e_of = 1'b0;

  always #10 clk = ~clk;

  spike_injector u_dut (
    .clk(clk), .rst(rst), .lane_lo_i(lane_lo), .lane_hi_i(lane_hi),
    .lane_valid_i(lane_valid), .step_tick_i(tick), .layer_sel_i(layer_sel),
    .cur_layer_i(cur_layer), .neuron_spike_i(nspk), .spike_o(spike),
    .override_o(ovr), .inject_active_o(act), .underflow_o(uf), .overflow_o(of)
  );

  task automatic check(string req, logic [31:0] actual, logic [31:0] expected);
    n_run++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic logic [7:0] mux_ref(logic a, logic [2:0] cl, logic [2:0] ls,
                                         logic [7:0] o, logic [7:0] own);
    return (a && cl == ls) ? o : own;
  endfunction

  // R2 R3 R6: a word takes two edges to land; the third negedge is safe for a tick
  task automatic send(logic [7:0] b);
    @(negedge clk); lane_lo = b[3:0]; lane_hi = b[7:4]; lane_valid = 1'b1;
    @(negedge clk); lane_valid = 1'b0; lane_lo = ~b[3:0]; lane_hi = ~b[7:4];
    if (q.size() < DEPTH) q.push_back(b); else e_of = 1'b1;
  endtask

  // R3 R4 R5
  task automatic do_tick();
    logic was_empty;
    @(negedge clk); tick = 1'b1;
    was_empty = (q.size() == 0);
    if (was_empty) begin e_ovr = '0; e_act = 1'b0; end
    else begin e_ovr = q.pop_front(); e_act = 1'b1; end
    @(posedge clk); #1;
    check("R3/R4 override", ovr, e_ovr);
    check("R4 active", act, e_act);
    check("R5 underflow pulse", uf, was_empty);
    check("R6 overflow flag", of, e_of);
    @(negedge clk); tick = 1'b0;
    @(posedge clk); #1;
    check("R5 underflow one cycle", uf, 1'b0);
    check("R4 hold", ovr, e_ovr);
  endtask

  // R7
  task automatic mux_check(logic [2:0] cl, logic [2:0] ls, logic [7:0] own);
    @(negedge clk); cur_layer = cl; layer_sel = ls; nspk = own;
    @(posedge clk); #1;
    check("R7 spike mux", spike, mux_ref(e_act, cl, ls, e_ovr, own));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset override", ovr, 8'h00);
    check("R1 reset spike", spike, 8'h00);
    check("R1 reset flags", {act, uf, of}, 3'b000);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", {ovr, spike, act, uf, of}, '0);

    // R5: tick with nothing stored
    do_tick();
    // R2: nibble placement, directed patterns
    send(8'hA5); send(8'h0F); send(8'hF0);
    do_tick(); mux_check(3'd0, 3'd0, 8'h3C);
    do_tick(); mux_check(3'd5, 3'd5, 8'h00);
    do_tick(); mux_check(3'd1, 3'd2, 8'h81);
    do_tick(); mux_check(3'd0, 3'd0, 8'h77);

    // R6: fill past depth, then drain in order
    for (int i = 0; i < DEPTH + 2; i++) send(8'(i * 13 + 1));
    for (int i = 0; i < DEPTH + 1; i++) do_tick();
    check("R6 overflow sticky", of, 1'b1);

    // mixed random stimulus
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 5)      send(8'($urandom));
      else if (r < 8) do_tick();
      else            mux_check(3'($urandom), 3'($urandom % 2), 8'($urandom));
    end
    while (q.size() > 0) do_tick();
    do_tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule